// File: doc/BRIEF.md
# Backplane I/O Slave Interface

This block is the bus-facing logic of a peripheral card that sits on an 8-bit asynchronous backplane. The backplane carries a 20-bit address, an 8-bit data byte, a 3-bit command code and an active-low data strobe. The card claims a 16-byte window inside a 4 KB I/O space. The window base comes from an 8-bit configuration input, normally set by jumpers, which is compared against address bits 11..4. When the master issues an I/O read or an I/O write into that window, the block turns the bus cycle into a single-cycle request on a simple local register port. It then waits for the local device to answer and completes the bus cycle with either an acknowledge or a transfer error.

All bus inputs are re-timed through a two-flop synchroniser onto the local clock before they are decoded. The cycle is fully handshaken. The slave waits as long as the local device needs. It then keeps its acknowledge or error, and the read byte, in place until the master releases the strobe. Only after that does it return to idle. The acknowledge and error lines are wired-OR and active low, so they appear here as pull-enable outputs: a 1 means the line is driven low, and a 0 means it is released. The read data byte has its own output enable.

Top module: `iosl_slave`

## Requirements
- R1: While `bus_rst_n` is low at a clock edge, every output is forced to 0 after that edge. This covers `bus_ack_pull`, `bus_err_pull`, `bus_rdata_oe`, `bus_rdata`, `loc_rd`, `loc_wr`, `loc_addr` and `loc_wdata`, and the controller returns to idle.
- R2: An I/O read has command code 3'b101 on `bus_cmd[2:0]`. For an I/O read that hits the window at an implemented offset, `loc_rd` is high for exactly one clock, with `loc_addr` equal to `bus_addr[3:0]`. When `loc_done` arrives, `loc_rdata` is captured, `bus_ack_pull` is raised and `bus_rdata_oe` is set, with `bus_rdata` equal to the captured byte.
- R3: An I/O write has command code 3'b100. For an I/O write that hits the window at an implemented offset, `loc_wr` is high for exactly one clock, with `loc_addr` equal to `bus_addr[3:0]` and `loc_wdata` equal to `bus_wdata`. When `loc_done` arrives, `bus_ack_pull` rises and `bus_rdata_oe` stays 0.
- R4: A window hit requires two things: `bus_addr[11:4]` equal to `card_base`, and `bus_addr[19:12]` all zero.
- R5: A cycle whose command is anything other than 3'b101 or 3'b100 produces no local strobe, no acknowledge and no error, however long the strobe is held. This covers 3'b111, 3'b110, 3'b011 and the reserved codes 3'b010, 3'b001 and 3'b000. A cycle with a good command that misses the window produces the same silence.
- R6: Bit k of the parameter IMPL_MASK marks offset k as implemented; the default is 16'h00FF, so offsets 8..15 are unimplemented. A read or write to an unimplemented offset raises `bus_err_pull` and never pulses `loc_rd` or `loc_wr`.
- R7: A `loc_fail` pulse, when no `loc_done` arrives with it, completes the cycle with `bus_err_pull`. In that case `bus_ack_pull` stays 0 and `bus_rdata_oe` stays 0.
- R8: `bus_ack_pull` or `bus_err_pull` rises on the clock edge that samples the `loc_done` or `loc_fail` pulse. The slave waits for that pulse for any number of cycles, with both lines released meanwhile.
- R9: Once raised, the acknowledge or error stays asserted, and `bus_rdata` stays unchanged, while the strobe remains low. The response is released on the third clock edge after `bus_dstb_n` goes high.
- R10: A cycle starts only after the low strobe has passed through the two-flop synchroniser. For a window hit, the local strobe appears on the third clock edge after `bus_dstb_n` goes low. For an unimplemented offset, the error appears on that same third edge.
- R11: `bus_ack_pull` and `bus_err_pull` are never asserted together, and `bus_rdata_oe` is never asserted without `bus_ack_pull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| bus_rst_n | input | 1 | Active-low system reset, sampled synchronously |
| bus_addr | input | 20 | Backplane address |
| bus_cmd | input | 3 | Command modifier code |
| bus_dstb_n | input | 1 | Active-low data strobe |
| bus_wdata | input | 8 | Data byte from the master |
| card_base | input | 8 | Configured window base, compared with address bits 11..4 |
| bus_rdata | output | 8 | Read data byte toward the backplane |
| bus_rdata_oe | output | 1 | Drive enable for `bus_rdata` |
| bus_ack_pull | output | 1 | 1 pulls the acknowledge line low |
| bus_err_pull | output | 1 | 1 pulls the transfer-error line low |
| loc_addr | output | 4 | Register offset for the local device |
| loc_rd | output | 1 | One-cycle local read request |
| loc_wr | output | 1 | One-cycle local write request |
| loc_wdata | output | 8 | Write byte for the local device |
| loc_rdata | input | 8 | Read byte from the local device, valid with `loc_done` |
| loc_done | input | 1 | One-cycle pulse: local access succeeded |
| loc_fail | input | 1 | One-cycle pulse: local access failed |

## Verification
A controller stuck in a wait state shows as an acknowledge that never follows the local response. A controller that leaves idle on a foreign cycle shows as a stray local strobe. Either is visible at the ports within one clock of the stimulus that exposes it. Latency faults in the synchroniser or the release path move the local strobe or the release by at least one cycle, and exact edge counting catches that at the next negative edge. A wrongly captured read byte, or a byte that is lost later, appears on `bus_rdata` during the hold phase. The local device changes its data immediately after the response pulse, so a late capture shows the altered byte instead of the expected one.

// File: rtl/iosl_pkg.sv
package iosl_pkg;

    localparam logic [2:0] CMD_IO_RD = 3'b101;
    localparam logic [2:0] CMD_IO_WR = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_WAIT,
        ST_HOLD_ACK,
        ST_HOLD_ERR
    } iosl_state_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE,
        ACC_BAD
    } iosl_kind_e;

endpackage

// File: rtl/iosl_sync.sv
module iosl_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            s2_q <= RST_VAL;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/iosl_decode.sv
module iosl_decode
    import iosl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int OFS_W  = 4,
    parameter int SEL_W  = 8,
    parameter logic [(2**OFS_W)-1:0] IMPL_MASK = 16'h00FF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        cmd,
    input  logic [SEL_W-1:0]  base,
    output iosl_kind_e        kind,
    output logic [OFS_W-1:0]  ofs
);
    localparam int IO_TOP = OFS_W + SEL_W;

    logic sel_hit, upper_zero, implemented;

    assign ofs         = addr[OFS_W-1:0];
    assign sel_hit     = (addr[IO_TOP-1:OFS_W] == base);
    assign implemented = IMPL_MASK[ofs];

    generate
        if (ADDR_W > IO_TOP) begin : g_upper
            assign upper_zero = (addr[ADDR_W-1:IO_TOP] == '0);
        end else begin : g_noupper
            assign upper_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        kind = ACC_NONE;
        if (sel_hit && upper_zero && (cmd == CMD_IO_RD || cmd == CMD_IO_WR)) begin
            if (!implemented)
                kind = ACC_BAD;
            else if (cmd == CMD_IO_RD)
                kind = ACC_READ;
            else
                kind = ACC_WRITE;
        end
    end
endmodule

// File: rtl/iosl_ctrl.sv
module iosl_ctrl
    import iosl_pkg::*;
#(
    parameter int OFS_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb,
    input  iosl_kind_e        kind,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    input  logic              loc_done,
    input  logic              loc_fail,
    output logic [OFS_W-1:0]  loc_addr,
    output logic              loc_rd,
    output logic              loc_wr,
    output logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    output logic              bus_ack_pull,
    output logic              bus_err_pull
);
    typedef struct packed {
        iosl_state_e       st;
        logic              rd;
        logic              wr;
        logic              is_rd;
        logic [OFS_W-1:0]  addr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
        logic              oe;
        logic              ack;
        logic              err;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{st: ST_IDLE, default: '0};

    ctrl_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        c_d.rd = 1'b0;
        c_d.wr = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (strb) begin
                    unique case (kind)
                        ACC_READ: begin
                            c_d.st    = ST_STROBE;
                            c_d.rd    = 1'b1;
                            c_d.is_rd = 1'b1;
                            c_d.addr  = ofs;
                        end
                        ACC_WRITE: begin
                            c_d.st    = ST_STROBE;
                            c_d.wr    = 1'b1;
                            c_d.is_rd = 1'b0;
                            c_d.addr  = ofs;
                            c_d.wdat  = wdata;
                        end
                        ACC_BAD: begin
                            c_d.st  = ST_HOLD_ERR;
                            c_d.err = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            ST_STROBE, ST_WAIT: begin
                if (loc_done) begin
                    c_d.st  = ST_HOLD_ACK;
                    c_d.ack = 1'b1;
                    c_d.oe  = c_q.is_rd;
                    if (c_q.is_rd)
                        c_d.rdat = loc_rdata;
                end else if (loc_fail) begin
                    c_d.st  = ST_HOLD_ERR;
                    c_d.err = 1'b1;
                end else begin
                    c_d.st = ST_WAIT;
                end
            end
            ST_HOLD_ACK, ST_HOLD_ERR: begin
                if (!strb) begin
                    c_d.st  = ST_IDLE;
                    c_d.ack = 1'b0;
                    c_d.err = 1'b0;
                    c_d.oe  = 1'b0;
                end
            end
            default: c_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= CTRL_RST;
        else     c_q <= c_d;
    end

    assign loc_addr     = c_q.addr;
    assign loc_rd       = c_q.rd;
    assign loc_wr       = c_q.wr;
    assign loc_wdata    = c_q.wdat;
    assign bus_rdata    = c_q.rdat;
    assign bus_rdata_oe = c_q.oe;
    assign bus_ack_pull = c_q.ack;
    assign bus_err_pull = c_q.err;

    // R11: the two completion lines are exclusive, and data is driven only with acknowledge
    a_r11_ack_err_excl: assert property (@(posedge clk) disable iff (rst)
        !(bus_ack_pull && bus_err_pull));
    a_r11_oe_needs_ack: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_oe |-> bus_ack_pull);
    // R2, R3: local requests are single-cycle and never both
    a_r2_rd_pulse: assert property (@(posedge clk) disable iff (rst)
        loc_rd |=> !loc_rd);
    a_r3_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        loc_wr |=> !loc_wr);
    a_r3_rd_wr_excl: assert property (@(posedge clk) disable iff (rst)
        !(loc_rd && loc_wr));
    // R8: an acknowledge only follows a local success pulse
    a_r8_ack_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack_pull) |-> $past(loc_done));
    // R9: read byte held while acknowledge stays up; release once strobe gone
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        (bus_ack_pull && $past(bus_ack_pull)) |-> $stable(bus_rdata));
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        ((bus_ack_pull || bus_err_pull) && !strb) |=> !(bus_ack_pull || bus_err_pull));
endmodule

// File: rtl/iosl_slave.sv
module iosl_slave
    import iosl_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 4,
    parameter int SEL_W  = 8,
    parameter logic [(2**OFS_W)-1:0] IMPL_MASK = 16'h00FF
) (
    input  logic              clk,
    input  logic              bus_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_cmd,
    input  logic              bus_dstb_n,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [SEL_W-1:0]  card_base,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    output logic              bus_ack_pull,
    output logic              bus_err_pull,
    output logic [OFS_W-1:0]  loc_addr,
    output logic              loc_rd,
    output logic              loc_wr,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic [DATA_W-1:0] loc_rdata,
    input  logic              loc_done,
    input  logic              loc_fail
);
    localparam int SYNC_W = 1 + 3 + ADDR_W + DATA_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {(SYNC_W-1){1'b0}}};

    logic                rst;
    logic [SYNC_W-1:0]   sync_q;
    logic                dstb_n_s;
    logic [2:0]          cmd_s;
    logic [ADDR_W-1:0]   addr_s;
    logic [DATA_W-1:0]   wdata_s;
    iosl_kind_e          kind;
    logic [OFS_W-1:0]    ofs;

    assign rst = !bus_rst_n;

    iosl_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({bus_dstb_n, bus_cmd, bus_addr, bus_wdata}),
        .q   (sync_q)
    );

    assign {dstb_n_s, cmd_s, addr_s, wdata_s} = sync_q;

    iosl_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SEL_W(SEL_W), .IMPL_MASK(IMPL_MASK)
    ) decode_i (
        .addr (addr_s),
        .cmd  (cmd_s),
        .base (card_base),
        .kind (kind),
        .ofs  (ofs)
    );

    iosl_ctrl #(.OFS_W(OFS_W), .DATA_W(DATA_W)) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .strb         (!dstb_n_s),
        .kind         (kind),
        .ofs          (ofs),
        .wdata        (wdata_s),
        .loc_rdata    (loc_rdata),
        .loc_done     (loc_done),
        .loc_fail     (loc_fail),
        .loc_addr     (loc_addr),
        .loc_rd       (loc_rd),
        .loc_wr       (loc_wr),
        .loc_wdata    (loc_wdata),
        .bus_rdata    (bus_rdata),
        .bus_rdata_oe (bus_rdata_oe),
        .bus_ack_pull (bus_ack_pull),
        .bus_err_pull (bus_err_pull)
    );

    // R1: one clock into reset, every output is released
    a_r1_reset_release: assert property (@(posedge clk)
        $past(rst) |-> !(bus_ack_pull || bus_err_pull || bus_rdata_oe || loc_rd || loc_wr));
endmodule

// File: tb/iosl_slave_tb_top.sv
module iosl_slave_tb_top;
    logic        clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [2:0]  bus_cmd = 3'b000;
    logic        bus_dstb_n = 1'b1;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  card_base = 8'h5A;
    logic [7:0]  bus_rdata;
    logic        bus_rdata_oe, bus_ack_pull, bus_err_pull;
    logic [3:0]  loc_addr;
    logic        loc_rd, loc_wr;
    logic [7:0]  loc_wdata;
    logic [7:0]  loc_rdata = '0;
    logic        loc_done = 1'b0, loc_fail = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    iosl_slave dut_i (
        .clk(clk), .bus_rst_n(bus_rst_n), .bus_addr(bus_addr), .bus_cmd(bus_cmd),
        .bus_dstb_n(bus_dstb_n), .bus_wdata(bus_wdata), .card_base(card_base),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .bus_ack_pull(bus_ack_pull),
        .bus_err_pull(bus_err_pull), .loc_addr(loc_addr), .loc_rd(loc_rd), .loc_wr(loc_wr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_done(loc_done), .loc_fail(loc_fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 ignore, 1 read, 2 write, 3 unimplemented offset (R4, R5, R6)
    function automatic int exp_kind(input logic [19:0] a, input logic [2:0] c, input logic [7:0] b);
        if (a[19:12] != 8'h00 || a[11:4] != b) return 0;
        if (c != 3'b101 && c != 3'b100) return 0;
        if (a[3:0] >= 4'd8) return 3;
        return (c == 3'b101) ? 1 : 2;
    endfunction

    function automatic logic [3:0] outs();
        return {bus_ack_pull, bus_err_pull, loc_rd, loc_wr};
    endfunction

    task automatic release_strobe(input bit expect_resp);
        bus_dstb_n = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            if (expect_resp) begin
                if (i < 3) chk(bus_ack_pull || bus_err_pull, "R9 response held after strobe high", 0, 1);
                else       chk(!(bus_ack_pull || bus_err_pull), "R9 released on third edge", 1, 0);
            end
        end
        bus_addr = 20'($urandom);
    endtask

    task automatic bus_cycle(input logic [19:0] a, input logic [2:0] c, input logic [7:0] wd,
                             input bit fail, input int w, input int hold);
        int k;
        int n;
        logic [7:0] rv;
        k = exp_kind(a, c, card_base);
        @(negedge clk);
        bus_addr = a; bus_cmd = c; bus_wdata = wd; bus_dstb_n = 1'b0;
        if (k == 0) begin
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                chk(outs() == 4'b0000, "R5 foreign or missed cycle ignored", int'(outs()), 0);
            end
            release_strobe(1'b0);
            return;
        end
        n = 0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (outs() != 4'b0000) begin n = i; break; end
        end
        chk(n == 3, "R10 start on third edge after strobe", n, 3);
        if (k == 3) begin
            chk(outs() == 4'b0100, "R6 unimplemented offset gives error only", int'(outs()), 4'b0100);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                chk(outs() == 4'b0100, "R9 error held while strobe low", int'(outs()), 4'b0100);
            end
            release_strobe(1'b1);
            return;
        end
        if (k == 1) chk(loc_rd && !loc_wr, "R2 read request pulse", int'({loc_rd, loc_wr}), 2);
        else begin
            chk(loc_wr && !loc_rd, "R3 write request pulse", int'({loc_rd, loc_wr}), 1);
            chk(loc_wdata == wd, "R3 write data", loc_wdata, wd);
        end
        chk(loc_addr == a[3:0], "R2 R3 local offset", loc_addr, a[3:0]);
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            chk(outs() == 4'b0000, "R8 released while waiting, single pulse", int'(outs()), 0);
        end
        rv = 8'($urandom);
        loc_rdata = rv;
        if (fail) loc_fail = 1'b1; else loc_done = 1'b1;
        @(negedge clk);
        loc_fail = 1'b0; loc_done = 1'b0; loc_rdata = ~rv;
        if (fail) begin
            chk(bus_err_pull && !bus_ack_pull && !bus_rdata_oe, "R7 local failure gives error",
                int'({bus_ack_pull, bus_err_pull, bus_rdata_oe}), 3'b010);
        end else begin
            chk(bus_ack_pull && !bus_err_pull, "R8 acknowledge one edge after done",
                int'({bus_ack_pull, bus_err_pull}), 2'b10);
            chk(bus_rdata_oe == (k == 1), "R2 R3 data enable per direction", bus_rdata_oe, (k == 1));
            if (k == 1) chk(bus_rdata == rv, "R2 read byte captured", bus_rdata, rv);
        end
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk((bus_ack_pull || bus_err_pull) && (fail || k != 1 || bus_rdata == rv),
                "R9 response and byte held", bus_rdata, rv);
        end
        release_strobe(1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D0C_5E11));
        repeat (3) @(negedge clk);
        // R1: outputs zero under reset
        chk({bus_rdata, bus_rdata_oe, bus_ack_pull, bus_err_pull, loc_rd, loc_wr, loc_addr, loc_wdata} == '0,
            "R1 reset state", int'(outs()), 0);
        bus_rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        bus_cycle({8'h00, 8'h5A, 4'h3}, 3'b101, 8'h00, 1'b0, 0, 2);   // R2 immediate done
        bus_cycle({8'h00, 8'h5A, 4'h7}, 3'b100, 8'hC3, 1'b0, 9, 1);   // R3 long wait
        bus_cycle({8'h00, 8'h5A, 4'h8}, 3'b101, 8'h00, 1'b0, 0, 2);   // R6 first unimplemented
        bus_cycle({8'h00, 8'h5A, 4'hF}, 3'b100, 8'h11, 1'b0, 0, 0);   // R6
        bus_cycle({8'h00, 8'h5A, 4'h0}, 3'b101, 8'h00, 1'b1, 3, 1);   // R7
        bus_cycle({8'h01, 8'h5A, 4'h1}, 3'b101, 8'h00, 1'b0, 0, 0);   // R4 upper bits set
        bus_cycle({8'h00, 8'h5B, 4'h1}, 3'b101, 8'h00, 1'b0, 0, 0);   // R4 wrong base
        for (int c = 0; c < 8; c++)
            if (c != 5 && c != 4)
                bus_cycle({8'h00, 8'h5A, 4'h2}, 3'(c), 8'h00, 1'b0, 0, 0); // R5

        // reset in mid transfer (R1)
        @(negedge clk);
        bus_addr = {8'h00, 8'h5A, 4'h4}; bus_cmd = 3'b101; bus_dstb_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_rst_n = 1'b0;
        @(negedge clk);
        chk({bus_rdata_oe, bus_ack_pull, bus_err_pull, loc_rd, loc_wr} == '0,
            "R1 reset during transfer", int'(outs()), 0);
        bus_dstb_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // random mix
        for (int t = 0; t < 150; t++) begin
            logic [19:0] a;
            logic [2:0]  c;
            int sel;
            sel = int'($urandom_range(0, 9));
            c = ($urandom_range(0, 3) != 0) ? ($urandom_range(0, 1) ? 3'b101 : 3'b100) : 3'($urandom);
            if (sel < 7)       a = {8'h00, card_base, 4'($urandom)};
            else if (sel == 7) a = {8'($urandom_range(1, 255)), card_base, 4'($urandom)};
            else               a = {8'h00, card_base ^ 8'($urandom_range(1, 255)), 4'($urandom)};
            bus_cycle(a, c, 8'($urandom), ($urandom_range(0, 4) == 0),
                      int'($urandom_range(0, 6)), int'($urandom_range(0, 3)));
            if (t % 50 == 49) card_base = 8'($urandom);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule